// File: doc/BRIEF.md
# Leveled interrupt priority controller

This block gathers interrupt requests from a set of peripheral sources and turns them into one interrupt line toward the CPU. Each source carries a 3-bit priority level and a request flag. Both sit in 16-bit control words that a simple register bus reaches, with two sources packed into each word. Every cycle a resolver picks the pending, enabled source with the numerically lowest level. It then compares that level against a 3-bit acceptance mask that the CPU writes. When the mask is strictly above the winning level, a latched request flop toward the CPU is set.

Sources come in two kinds, chosen per source by a parameter. An edge-latched source keeps a request flop. A peripheral event pulse sets it, and software can set or clear it through its request bit. A grouped source has no flop: its request bit is the live OR of a small group of peripheral lines, and it cannot be written. The CPU learns which source won by reading a vector word. That read drops the CPU request, and it also clears the winner's flop when the winner is edge-latched. Writing the mask drops the CPU request as well. If a source still qualifies after the drop, the request rises again on the next clock.

With the default parameters there are four control words (eight sources). Sources 6 and 7 are grouped, each with three lines. Control words sit at addresses 0 to 3, the mask at address 4 and the vector word at address 5.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every level field reads 111, every request bit reads 0, the mask reads 0, the vector word reads 0 and cpu_irq is 0.
- R2: A source whose level is 111 never wins, even with its request bit set; levels 000 to 110 make it eligible.
- R3: cpu_irq is set on the clock after the winning source's level is strictly below the mask (level 6 needs mask 7; mask 0 accepts nothing).
- R4: Among eligible pending sources the lowest level wins, and on equal levels the lower index wins. A vector read (address 5) returns bit 15 = 1 and the winner index in bits 2:0, or all zeros when there is no winner.
- R5: Control word k (address k) holds source 2k in its low byte and source 2k+1 in its high byte: request flags at bits 3 and 11, levels at bits 7:5 and 15:13, all other bits read 0. A write updates both level fields. The mask sits in bits 2:0 of address 4.
- R6: For an edge-latched source, an event pulse sets its request flop, and a bus write loads the flop from the written request bit. An event in the same cycle wins over a clear.
- R7: For a grouped source the request bit reads the OR of its live lines, and writes to that bit have no effect.
- R8: cpu_irq stays set, even after the request that caused it is withdrawn, until a vector read or a mask write clears it on that clock.
- R9: A vector read clears the request flop of an edge-latched winner; a grouped winner keeps requesting.
- R10: After cpu_irq is cleared, it is set again on the next clock if the current winner still passes the mask compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address: 0-3 control, 4 mask, 5 vector |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when no read |
| edge_evt | input | 8 | Event pulses for edge-latched sources |
| grp_lines | input | 24 | Live request lines, three per source |
| cpu_irq | output | 1 | Latched interrupt request to the CPU |

## Verification
The assertions watch the CPU request flop on every cycle. It must drop after a vector read or a mask write, hold otherwise, rise only after an accepted winner, and always rise after one. They also check that a winner is eligible and pending, and that an edge flop follows events and vector clears. The arbitration order, the packing of the control words, the refusal of writes to grouped request bits, and the re-raise after a clear are shown only by the bench's scenarios. There a behavioural model is compared with the outputs every clock.

// File: rtl/lic_pkg.sv
package lic_pkg;
    typedef logic [2:0] lvl_t;
    localparam lvl_t LVL_OFF = 3'b111;

    typedef struct packed {
        logic req;
        lvl_t lvl;
    } edge_src_t;

    typedef struct packed {
        lvl_t lvl;
    } grp_src_t;

    typedef struct packed {
        lvl_t mask;
        logic irq;
    } gate_t;
endpackage

// File: rtl/lic_source.sv
module lic_source
    import lic_pkg::*;
#(
    parameter bit GROUPED = 1'b0,
    parameter int GW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic [GW-1:0] lines,
    input  logic          wr_en,
    input  logic          wr_req,
    input  lvl_t          wr_lvl,
    input  logic          vclr,
    output logic          req,
    output lvl_t          lvl
);
    generate
        if (GROUPED) begin : g_grp
            grp_src_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (wr_en) st_d.lvl = wr_lvl;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '{lvl: LVL_OFF};
                else        st_q <= st_d;
            end

            assign req = |lines;
            assign lvl = st_q.lvl;

            logic unused_grp;
            assign unused_grp = ^{evt, wr_req, vclr};
        end else begin : g_edge
            edge_src_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (wr_en) begin
                    st_d.lvl = wr_lvl;
                    st_d.req = wr_req;
                end
                if (vclr) st_d.req = 1'b0;
                if (evt)  st_d.req = 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '{req: 1'b0, lvl: LVL_OFF};
                else        st_q <= st_d;
            end

            assign req = st_q.req;
            assign lvl = st_q.lvl;

            logic unused_edge;
            assign unused_edge = ^lines;

            // R6: an event pulse always leaves the flop set
            p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
                evt |=> req);
            // R9: a vector clear without a competing event empties the flop
            p_vclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (vclr && !evt && !wr_en) |=> !req);
        end
    endgenerate
endmodule

// File: rtl/lic_resolver.sv
module lic_resolver
    import lic_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]       req,
    input  lvl_t [NSRC-1:0]       lvl,
    output logic                  win_valid,
    output logic [IDX_W-1:0]      win_idx,
    output lvl_t                  win_lvl
);
    logic [NSRC-1:0] elig;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_elig
            assign elig[i] = req[i] && (lvl[i] != LVL_OFF);
        end
    endgenerate

    // Scan from index 0 upward; strict less-than keeps the lower index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = LVL_OFF;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!win_valid || lvl[i] < win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = lvl[i];
            end
        end
    end
endmodule

// File: rtl/lic_irq_gate.sv
module lic_irq_gate
    import lic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_valid,
    input  lvl_t win_lvl,
    input  logic mask_wr,
    input  lvl_t mask_wdata,
    input  logic vec_rd,
    output lvl_t mask,
    output logic accept,
    output logic cpu_irq
);
    gate_t st_d, st_q;
    logic  clr;

    assign accept = win_valid && (st_q.mask > win_lvl);
    assign clr    = vec_rd || mask_wr;

    always_comb begin
        st_d = st_q;
        if (mask_wr) st_d.mask = mask_wdata;
        if (clr)     st_d.irq  = 1'b0;
        else         st_d.irq  = st_q.irq || accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mask: 3'b000, irq: 1'b0};
        else        st_q <= st_d;
    end

    assign mask    = st_q.mask;
    assign cpu_irq = st_q.irq;

    // R8: a vector read or mask write drops the request
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !cpu_irq);
    // R8: without a clear the request is held
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !clr) |=> cpu_irq);
    // R3: an accepted winner raises the request
    p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !clr) |=> cpu_irq);
    // R3: the request only rises after an accepted winner
    p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(accept));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int                     NUM_PAIRS   = 4,
    parameter int                     GW          = 3,
    parameter int                     AW          = 4,
    parameter logic [2*NUM_PAIRS-1:0] GROUPED_MAP = 8'hC0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_we,
    input  logic [AW-1:0]             bus_addr,
    input  logic [15:0]               bus_wdata,
    output logic [15:0]               bus_rdata,
    input  logic [2*NUM_PAIRS-1:0]    edge_evt,
    input  logic [2*NUM_PAIRS*GW-1:0] grp_lines,
    output logic                      cpu_irq
);
    localparam int            NSRC      = 2 * NUM_PAIRS;
    localparam int            IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [AW-1:0] MASK_ADDR = AW'(NUM_PAIRS);
    localparam logic [AW-1:0] VEC_ADDR  = AW'(NUM_PAIRS + 1);

    logic [NSRC-1:0]   src_req;
    lvl_t [NSRC-1:0]   src_lvl;
    logic [NSRC-1:0]   src_vclr;
    logic [NUM_PAIRS-1:0] pair_wr;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    lvl_t              win_lvl;
    lvl_t              mask;
    logic              accept;
    logic              mask_wr;
    logic              vec_rd;
    logic              rd_en;

    assign rd_en   = bus_sel && !bus_we;
    assign mask_wr = bus_sel && bus_we && (bus_addr == MASK_ADDR);
    assign vec_rd  = rd_en && (bus_addr == VEC_ADDR);

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            assign pair_wr[p] = bus_sel && bus_we && (bus_addr == AW'(p));
        end

        for (genvar i = 0; i < NSRC; i++) begin : g_src
            localparam int LO = (i % 2) * 8;
            assign src_vclr[i] = vec_rd && win_valid && (win_idx == IDX_W'(i));
            lic_source #(
                .GROUPED (GROUPED_MAP[i]),
                .GW      (GW)
            ) u_src (
                .clk    (clk),
                .rst_n  (rst_n),
                .evt    (edge_evt[i]),
                .lines  (grp_lines[i*GW +: GW]),
                .wr_en  (pair_wr[i/2]),
                .wr_req (bus_wdata[LO+3]),
                .wr_lvl (bus_wdata[LO+7 -: 3]),
                .vclr   (src_vclr[i]),
                .req    (src_req[i]),
                .lvl    (src_lvl[i])
            );
        end
    endgenerate

    lic_resolver #(
        .NSRC  (NSRC),
        .IDX_W (IDX_W)
    ) u_res (
        .req       (src_req),
        .lvl       (src_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    lic_irq_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_valid  (win_valid),
        .win_lvl    (win_lvl),
        .mask_wr    (mask_wr),
        .mask_wdata (bus_wdata[2:0]),
        .vec_rd     (vec_rd),
        .mask       (mask),
        .accept     (accept),
        .cpu_irq    (cpu_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (bus_addr == AW'(p)) begin
                    bus_rdata[3]     = src_req[2*p];
                    bus_rdata[7:5]   = src_lvl[2*p];
                    bus_rdata[11]    = src_req[2*p+1];
                    bus_rdata[15:13] = src_lvl[2*p+1];
                end
            end
            if (bus_addr == MASK_ADDR) bus_rdata[2:0] = mask;
            if (bus_addr == VEC_ADDR && win_valid) begin
                bus_rdata[15]        = 1'b1;
                bus_rdata[IDX_W-1:0] = win_idx;
            end
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[12], bus_wdata[10:8], bus_wdata[4]};

    // R2: a disabled level never wins
    p_win_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_lvl != LVL_OFF));
    // R4: the winner is a pending source carrying the reported level
    p_win_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (src_req[win_idx] && src_lvl[win_idx] == win_lvl));
endmodule

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;
    localparam int NP   = 4;
    localparam int NSRC = 2 * NP;
    localparam int GW   = 3;
    localparam logic [NSRC-1:0] GRP = 8'hC0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [3:0]        bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [NSRC-1:0]   edge_evt = '0;
    logic [NSRC*GW-1:0] grp_lines = '0;
    logic              cpu_irq;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;
    string cur_req = "R1";

    // behavioural model state
    int lv[NSRC];
    bit rq[NSRC];
    int msk;
    bit irq;

    always #5 clk = ~clk;

    lvl_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .edge_evt(edge_evt), .grp_lines(grp_lines), .cpu_irq(cpu_irq)
    );

    function automatic bit req_now(int i);
        if (GRP[i]) return |grp_lines[i*GW +: GW];
        return rq[i];
    endfunction

    function automatic void pick(output bit found, output int w);
        int best = 8;
        found = 0;
        w = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_now(i) && lv[i] != 7 && lv[i] < best) begin
                best = lv[i];
                w = i;
                found = 1;
            end
        end
    endfunction

    function automatic logic [15:0] exp_rdata();
        logic [15:0] r = '0;
        bit f;
        int w;
        if (!(bus_sel && !bus_we)) return r;
        if (bus_addr < NP) begin
            int p = int'(bus_addr);
            r[3]     = req_now(2*p);
            r[7:5]   = 3'(lv[2*p]);
            r[11]    = req_now(2*p+1);
            r[15:13] = 3'(lv[2*p+1]);
        end else if (bus_addr == NP) begin
            r[2:0] = 3'(msk);
        end else if (bus_addr == NP + 1) begin
            pick(f, w);
            if (f) begin
                r[15] = 1'b1;
                r[2:0] = 3'(w);
            end
        end
        return r;
    endfunction

    task automatic model_step();
        bit f;
        int w;
        bit rd, mw, cw;
        pick(f, w);
        rd = bus_sel && !bus_we && bus_addr == NP + 1;
        mw = bus_sel && bus_we && bus_addr == NP;
        cw = bus_sel && bus_we && bus_addr < NP;
        for (int i = 0; i < NSRC; i++) begin
            int lo = (i % 2) * 8;
            if (cw && int'(bus_addr) == i / 2) begin
                lv[i] = int'(bus_wdata[lo+5 +: 3]);
                if (!GRP[i]) rq[i] = bus_wdata[lo+3];
            end
            if (!GRP[i] && rd && f && w == i) rq[i] = 0;
            if (!GRP[i] && edge_evt[i]) rq[i] = 1;
        end
        if (mw) msk = int'(bus_wdata[2:0]);
        if (rd || mw) irq = 0;
        else if (f && msk > lv[w]) irq = 1;
    endtask

    task automatic check(string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic cyc();
        #2;
        check("cpu_irq", {15'b0, cpu_irq}, {15'b0, irq});
        check("bus_rdata", bus_rdata, exp_rdata());
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [15:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = 4'(a); bus_wdata = d;
        cyc();
        bus_sel = 0; bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(int a);
        bus_sel = 1; bus_we = 0; bus_addr = 4'(a);
        cyc();
        bus_sel = 0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            n_cyc++;
            if (n_cyc > 20000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", n_cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < NSRC; i++) begin
            lv[i] = 7;
            rq[i] = 0;
        end
        msk = 0;
        irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values on every register
        cur_req = "R1";
        for (int a = 0; a <= NP + 1; a++) rd(a);

        // R5: control word packing
        cur_req = "R5";
        wr(0, 16'hE068);
        rd(0);
        wr(4, 16'h0005);
        rd(4);
        wr(4, 16'h0000);

        // R3: strict mask compare, level 3
        cur_req = "R3";
        wr(4, 16'h0003);
        idle(2);
        wr(4, 16'h0004);
        idle(2);

        // R8: request withdrawn, irq stays until vector read
        cur_req = "R8";
        wr(0, 16'hE060);
        idle(3);
        rd(5);
        idle(2);

        // R4: lowest level, tie to lower index
        cur_req = "R4";
        wr(2, 16'hE0A0);
        wr(1, 16'h4848);
        edge_evt[4] = 1'b1;
        cyc();
        edge_evt[4] = 1'b0;
        rd(5);
        // R9 and R10: edge winner cleared, irq rises again
        cur_req = "R10";
        idle(1);
        cur_req = "R9";
        rd(5);
        idle(1);
        rd(5);
        rd(5);
        idle(1);

        // R2: level 7 never wins
        cur_req = "R2";
        wr(2, 16'hE0E8);
        idle(1);
        rd(5);
        rd(2);

        // R7: grouped request bits ignore writes and follow lines
        cur_req = "R7";
        wr(3, 16'hC808);
        rd(3);
        grp_lines[7*GW +: GW] = 3'b010;
        cyc();
        rd(3);
        cur_req = "R9";
        rd(5);
        rd(5);
        cur_req = "R3";
        idle(2);
        wr(4, 16'h0007);
        idle(2);
        cur_req = "R4";
        grp_lines[6*GW +: GW] = 3'b100;
        rd(5);
        idle(1);
        grp_lines = '0;
        cyc();
        rd(3);
        rd(5);

        // R6: event sets flop, bus write sets and clears it
        cur_req = "R6";
        wr(1, 16'h4848);
        rd(1);
        wr(1, 16'h4040);
        rd(1);
        edge_evt[1] = 1'b1;
        wr(0, 16'h2020);
        edge_evt[1] = 1'b0;
        rd(0);

        // R8: mask write clears a set request, then R10 re-raise
        cur_req = "R8";
        idle(2);
        wr(4, 16'h0007);
        cur_req = "R10";
        idle(2);
        rd(5);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule